// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block looks for the divider settings of a phase-locked loop that bring its output as close as it can get to a requested frequency. A request gives a target frequency and a reference frequency, both in whole MHz, with a one-cycle `start` pulse. The engine then walks through the post-divider index, the reference divider M and the feedback multiplier N in a fixed nested order. It rejects any candidate whose comparison frequency (reference over M) or VCO frequency falls outside its window. It keeps the candidate with the smallest absolute error, measured in units of twice the requested frequency.

All arithmetic is unsigned and 32 bits wide. Every quotient comes from a single shared restoring divider that produces one quotient bit per cycle, so one search takes from a few hundred cycles to a few tens of thousands of cycles. The divider settings are fixed by parameters. By default the limits are: VCO 1000 to 2064 MHz, comparison frequency 12 to 38 MHz, M 1 to 255, N 8 to 255, and post-divide value 1 to 32.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, `busy`, `done` and `no_match` are 0. A `start` seen while the engine is idle or finished latches `target_mhz` and `ref_mhz`, and in the next cycle `busy` is 1 and `done` is 0. `busy` and `done` are never 1 together.
- R2: A `start` that arrives while `busy` is 1 has no effect. The search in progress finishes with the result for the inputs it latched.
- R3: Once `done` rises, `done` and all result outputs hold their values until the next accepted `start`.
- R4: A reported match meets all of the following: 12·M ≤ ref < 39·M; 8 ≤ N ≤ 255; floor(ref·N/M) lies between 1000 and the upper VCO limit.
- R5: Post-divider index k (0 to 14) selects the divide value d from the list 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32. `freq_out` = (VCO + floor(d/2)) / d, using integer division, where VCO = floor(ref·N/M).
- R6: The search computes T = 2·target and V = T + floor(T/50). The upper VCO limit becomes max(2064, V). The high divide bound is ceil(upper/V) and the low bound is floor(1000/V), each clamped to 1..32. Each bound becomes the first index in 0..13 whose divide value is at least the bound, or 14 if there is none. Indices from the low index to the high index inclusive are searched.
- R7: The scan order is: index ascending, then M ascending, then N from floor(V_k·M/ref) to ceil(V_k·M/ref), where V_k = T·d(k). A candidate replaces the best one only if its error |freq − T| is strictly smaller, so the earliest of several equal candidates is kept.
- R8: The search ends as soon as a candidate with zero error is found.
- R9: If no candidate qualifies, the outputs are M=255, N=8, index 1 and `freq_out`=0, and `no_match` is 1 while `done` is 1.
- R10: Each divide returns a quotient and remainder with q·d + r equal to the dividend and r < d, for any non-zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when the engine is not busy |
| target_mhz | input | 16 | Requested output frequency in MHz |
| ref_mhz | input | 16 | Reference frequency in MHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid, held until the next accepted start |
| m_out | output | 8 | Chosen reference divider M |
| n_out | output | 8 | Chosen feedback multiplier N |
| pl_out | output | 4 | Chosen post-divider index |
| freq_out | output | 32 | Achieved frequency, in doubled-MHz units |
| no_match | output | 1 | No candidate met the windows |

## Verification
One target is worked out by hand: the first index in its range fails the VCO window, so the exact-hit early exit has to land on the next index. Several pairs of target and reference are compared against an independent model of the search. These pairs cover exact hits, approximate hits where ties and the strict-improvement rule matter, high targets whose index range starts at zero, and large references where small M values are skipped by the comparison window. A reference below the comparison window separates the no-match defaults from a real result. A second request issued in the middle of a search shows whether it disturbs the result of the first.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int PL_TAB_N = 15;
  localparam int PL_IDX_W = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_TVCO, S_HI, S_LO, S_PL, S_M, S_NDIV, S_N, S_VDIV, S_LDIV, S_DONE
  } srch_state_t;

  // Post-divide value selected by an index; the list is not monotonic.
  function automatic logic [5:0] pl_div_of(input logic [PL_IDX_W-1:0] idx);
    case (idx)
      4'd0:  pl_div_of = 6'd1;
      4'd1:  pl_div_of = 6'd2;
      4'd2:  pl_div_of = 6'd3;
      4'd3:  pl_div_of = 6'd4;
      4'd4:  pl_div_of = 6'd5;
      4'd5:  pl_div_of = 6'd6;
      4'd6:  pl_div_of = 6'd8;
      4'd7:  pl_div_of = 6'd10;
      4'd8:  pl_div_of = 6'd12;
      4'd9:  pl_div_of = 6'd16;
      4'd10: pl_div_of = 6'd12;
      4'd11: pl_div_of = 6'd16;
      4'd12: pl_div_of = 6'd20;
      4'd13: pl_div_of = 6'd24;
      default: pl_div_of = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_q, q_d, r_q, r_d, d_q, d_d, n_q, n_d;
  logic [CW-1:0] c_q, c_d;
  logic          done_q, done_d;
  logic [W:0]    r_sh, diff;

  assign r_sh = {r_q, q_q[W-1]};
  assign diff = r_sh - {1'b0, d_q};

  always_comb begin
    q_d    = q_q;
    r_d    = r_q;
    d_d    = d_q;
    n_d    = n_q;
    c_d    = c_q;
    done_d = 1'b0;
    if (go) begin
      q_d = dividend;
      n_d = dividend;
      r_d = '0;
      d_d = divisor;
      c_d = CW'(W);
    end else if (c_q != '0) begin
      if (!diff[W]) begin
        r_d = diff[W-1:0];
        q_d = {q_q[W-2:0], 1'b1};
      end else begin
        r_d = r_sh[W-1:0];
        q_d = {q_q[W-2:0], 1'b0};
      end
      c_d = c_q - 1'b1;
      if (c_q == CW'(1)) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      n_q    <= '0;
      c_q    <= '0;
      done_q <= 1'b0;
    end else begin
      q_q    <= q_d;
      r_q    <= r_d;
      d_q    <= d_d;
      n_q    <= n_d;
      c_q    <= c_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quot = q_q;
  assign rem  = r_q;

  // R10: quotient and remainder reconstruct the dividend
  assert_div_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && d_q != '0) |->
      ((2*W)'(quot) * (2*W)'(d_q) + (2*W)'(rem) == (2*W)'(n_q)) && (rem < d_q));

endmodule

// File: rtl/pll_div_index.sv
module pll_div_index
  import pll_search_pkg::*;
#(
  parameter int BW = 6
) (
  input  logic [BW-1:0]       bound,
  output logic [PL_IDX_W-1:0] idx
);
  logic [PL_TAB_N-2:0] hit;

  for (genvar i = 0; i < PL_TAB_N - 1; i++) begin : g_cmp
    assign hit[i] = BW'(pl_div_of(PL_IDX_W'(i))) >= bound;
  end

  // First entry reaching the bound; the last entry is never a hit.
  always_comb begin
    idx = PL_IDX_W'(PL_TAB_N - 1);
    for (int i = PL_TAB_N - 2; i >= 0; i--) begin
      if (hit[i]) idx = PL_IDX_W'(i);
    end
  end

endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pll_search_pkg::*;
#(
  parameter int FW       = 16,
  parameter int DW       = 32,
  parameter int VCO_MIN  = 1000,
  parameter int VCO_MAX  = 2064,
  parameter int U_MIN    = 12,
  parameter int U_MAX    = 38,
  parameter int M_MIN    = 1,
  parameter int M_MAX    = 255,
  parameter int N_MIN    = 8,
  parameter int N_MAX    = 255,
  parameter int DIVV_MIN = 1,
  parameter int DIVV_MAX = 32,
  parameter int DEF_PL   = 1,
  parameter int SLACK_DEN = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [FW-1:0]       target_mhz,
  input  logic [FW-1:0]       ref_mhz,
  output logic                busy,
  output logic                done,
  output logic [7:0]          m_out,
  output logic [7:0]          n_out,
  output logic [PL_IDX_W-1:0] pl_out,
  output logic [DW-1:0]       freq_out,
  output logic                no_match
);
  localparam int MW = $clog2(M_MAX + 1);
  localparam int NW = $clog2(N_MAX + 1);
  localparam int BW = $clog2(DIVV_MAX + 1);
  localparam logic [DW-1:0] K_VMIN = DW'(VCO_MIN);
  localparam logic [DW-1:0] K_VMAX = DW'(VCO_MAX);
  localparam logic [DW-1:0] K_ULO  = DW'(U_MIN);
  localparam logic [DW-1:0] K_UHI  = DW'(U_MAX + 1);
  localparam logic [DW-1:0] K_MMIN = DW'(M_MIN);
  localparam logic [DW-1:0] K_MMAX = DW'(M_MAX);
  localparam logic [DW-1:0] K_NMIN = DW'(N_MIN);
  localparam logic [DW-1:0] K_NMAX = DW'(N_MAX);

  srch_state_t st_q, st_d;
  logic [DW-1:0] tclk_q, tclk_d, refv_q, refv_d, tvco_q, tvco_d, maxv_q, maxv_d;
  logic [DW-1:0] tvp_q, tvp_d, m_q, m_d, n_q, n_d, nhi_q, nhi_d;
  logic [DW-1:0] bf_q, bf_d, bdel_q, bdel_d, dvd_q, dvd_d, dvs_q, dvs_d;
  logic [PL_IDX_W-1:0] pl_q, pl_d, lo_q, lo_d, hi_q, hi_d, bpl_q, bpl_d;
  logic [MW-1:0] bm_q, bm_d;
  logic [NW-1:0] bn_q, bn_d;
  logic found_q, found_d, dgo_q, dgo_d;
  logic adv_m, adv_pl;

  logic          dv_done;
  logic [DW-1:0] dv_q, dv_r, ceil_q, v_new, err;
  logic [BW-1:0] hi_bound, lo_bound;
  logic [PL_IDX_W-1:0] hi_idx_w, lo_idx_w;
  logic [5:0]    dcur;

  function automatic logic [BW-1:0] clamp_div(input logic [DW-1:0] v);
    if (v < DW'(DIVV_MIN))      clamp_div = BW'(DIVV_MIN);
    else if (v > DW'(DIVV_MAX)) clamp_div = BW'(DIVV_MAX);
    else                        clamp_div = v[BW-1:0];
  endfunction

  pll_seq_divider #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(dgo_q), .dividend(dvd_q), .divisor(dvs_q),
    .done(dv_done), .quot(dv_q), .rem(dv_r)
  );

  assign ceil_q   = dv_q + DW'(dv_r != '0);
  assign hi_bound = clamp_div(ceil_q);
  assign lo_bound = clamp_div(dv_q);

  pll_div_index #(.BW(BW)) u_hi_idx (.bound(hi_bound), .idx(hi_idx_w));
  pll_div_index #(.BW(BW)) u_lo_idx (.bound(lo_bound), .idx(lo_idx_w));

  assign dcur  = pl_div_of(pl_q);
  assign v_new = tclk_q + dv_q;
  assign err   = (dv_q >= tclk_q) ? (dv_q - tclk_q) : (tclk_q - dv_q);

  // Next-state logic of the nested scan
  always_comb begin
    st_d = st_q;  tclk_d = tclk_q; refv_d = refv_q; tvco_d = tvco_q;
    maxv_d = maxv_q; tvp_d = tvp_q; m_d = m_q; n_d = n_q; nhi_d = nhi_q;
    bf_d = bf_q; bdel_d = bdel_q; dvd_d = dvd_q; dvs_d = dvs_q;
    pl_d = pl_q; lo_d = lo_q; hi_d = hi_q; bpl_d = bpl_q; bm_d = bm_q;
    bn_d = bn_q; found_d = found_q; dgo_d = 1'b0;
    adv_m = 1'b0; adv_pl = 1'b0;
    case (st_q)
      S_IDLE, S_DONE: begin
        if (start) begin
          tclk_d  = DW'(target_mhz) << 1;
          refv_d  = DW'(ref_mhz);
          found_d = 1'b0;
          bdel_d  = '1;
          dvd_d   = DW'(target_mhz) << 1;
          dvs_d   = DW'(SLACK_DEN);
          dgo_d   = 1'b1;
          st_d    = S_TVCO;
        end
      end
      S_TVCO: if (dv_done) begin
        tvco_d = v_new;
        maxv_d = (v_new > K_VMAX) ? v_new : K_VMAX;
        dvd_d  = (v_new > K_VMAX) ? v_new : K_VMAX;
        dvs_d  = v_new;
        dgo_d  = 1'b1;
        st_d   = S_HI;
      end
      S_HI: if (dv_done) begin
        hi_d  = hi_idx_w;
        dvd_d = K_VMIN;
        dvs_d = tvco_q;
        dgo_d = 1'b1;
        st_d  = S_LO;
      end
      S_LO: if (dv_done) begin
        lo_d = lo_idx_w;
        pl_d = lo_idx_w;
        st_d = S_PL;
      end
      S_PL: begin
        tvp_d = tclk_q * DW'(dcur);
        m_d   = K_MMIN;
        st_d  = S_M;
      end
      S_M: begin
        if (refv_q < K_ULO * m_q) begin
          adv_pl = 1'b1;
        end else if (refv_q >= K_UHI * m_q) begin
          adv_m = 1'b1;
        end else begin
          dvd_d = tvp_q * m_q;
          dvs_d = refv_q;
          dgo_d = 1'b1;
          st_d  = S_NDIV;
        end
      end
      S_NDIV: if (dv_done) begin
        if (dv_q > K_NMAX) begin
          adv_m = 1'b1;
        end else begin
          n_d   = dv_q;
          nhi_d = ceil_q;
          st_d  = S_N;
        end
      end
      S_N: begin
        if (n_q > nhi_q || n_q > K_NMAX) begin
          adv_m = 1'b1;
        end else if (n_q < K_NMIN) begin
          n_d = n_q + 1'b1;
        end else begin
          dvd_d = refv_q * n_q;
          dvs_d = m_q;
          dgo_d = 1'b1;
          st_d  = S_VDIV;
        end
      end
      S_VDIV: if (dv_done) begin
        if (dv_q >= K_VMIN && dv_q <= maxv_q) begin
          dvd_d = dv_q + DW'(dcur[5:1]);
          dvs_d = DW'(dcur);
          dgo_d = 1'b1;
          st_d  = S_LDIV;
        end else begin
          n_d  = n_q + 1'b1;
          st_d = S_N;
        end
      end
      S_LDIV: if (dv_done) begin
        if (err < bdel_q) begin
          bdel_d  = err;
          bf_d    = dv_q;
          bm_d    = m_q[MW-1:0];
          bn_d    = n_q[NW-1:0];
          bpl_d   = pl_q;
          found_d = 1'b1;
        end
        if (err == '0) begin
          st_d = S_DONE;
        end else begin
          n_d  = n_q + 1'b1;
          st_d = S_N;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (adv_m) begin
      if (m_q >= K_MMAX) adv_pl = 1'b1;
      else begin
        m_d  = m_q + 1'b1;
        st_d = S_M;
      end
    end
    if (adv_pl) begin
      if (pl_q >= hi_q) st_d = S_DONE;
      else begin
        pl_d = pl_q + 1'b1;
        st_d = S_PL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; tclk_q <= '0; refv_q <= '0; tvco_q <= '0; maxv_q <= '0;
      tvp_q <= '0; m_q <= '0; n_q <= '0; nhi_q <= '0; bf_q <= '0; bdel_q <= '0;
      dvd_q <= '0; dvs_q <= '0; pl_q <= '0; lo_q <= '0; hi_q <= '0;
      bpl_q <= '0; bm_q <= '0; bn_q <= '0; found_q <= 1'b0; dgo_q <= 1'b0;
    end else begin
      st_q <= st_d; tclk_q <= tclk_d; refv_q <= refv_d; tvco_q <= tvco_d;
      maxv_q <= maxv_d; tvp_q <= tvp_d; m_q <= m_d; n_q <= n_d; nhi_q <= nhi_d;
      bf_q <= bf_d; bdel_q <= bdel_d; dvd_q <= dvd_d; dvs_q <= dvs_d;
      pl_q <= pl_d; lo_q <= lo_d; hi_q <= hi_d; bpl_q <= bpl_d; bm_q <= bm_d;
      bn_q <= bn_d; found_q <= found_d; dgo_q <= dgo_d;
    end
  end

  assign busy     = (st_q != S_IDLE) && (st_q != S_DONE);
  assign done     = (st_q == S_DONE);
  assign no_match = done && !found_q;
  assign m_out    = found_q ? 8'(bm_q) : 8'(M_MAX);
  assign n_out    = found_q ? 8'(bn_q) : 8'(N_MIN);
  assign pl_out   = found_q ? bpl_q : PL_IDX_W'(DEF_PL);
  assign freq_out = found_q ? bf_q : '0;

  assert_busy_done_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done));
  assert_request_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tclk_q) && $stable(refv_q)));
  assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(m_out) && $stable(n_out) &&
      $stable(pl_out) && $stable(freq_out) && $stable(no_match)));
  assert_match_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_match) |-> (refv_q >= K_ULO * DW'(m_out) &&
      refv_q < K_UHI * DW'(m_out) && DW'(n_out) >= K_NMIN));
  assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_match) |-> (pl_out >= lo_q && pl_out <= hi_q));
  assert_nomatch_default_R9: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> (DW'(m_out) == K_MMAX && DW'(n_out) == K_NMIN &&
      pl_out == PL_IDX_W'(DEF_PL) && freq_out == '0));

endmodule

// File: tb/pll_coef_search_tb.sv
module pll_coef_search_tb_top;
  localparam int WD_LIMIT = 190000;

  logic        clk, rst_n, start;
  logic [15:0] target_mhz, ref_mhz;
  logic        busy, done, no_match;
  logic [7:0]  m_out, n_out;
  logic [3:0]  pl_out;
  logic [31:0] freq_out;

  int checks = 0;
  int fails  = 0;
  bit reported = 0;

  pll_coef_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .target_mhz(target_mhz),
    .ref_mhz(ref_mhz), .busy(busy), .done(done), .m_out(m_out), .n_out(n_out),
    .pl_out(pl_out), .freq_out(freq_out), .no_match(no_match)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WD_LIMIT);
    report();
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tab_div(input int i);
    case (i)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 5;
      5: return 6;  6: return 8;  7: return 10; 8: return 12; 9: return 16;
      10: return 12; 11: return 16; 12: return 20; 13: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int first_idx(input int b);
    for (int i = 0; i < 14; i++) if (tab_div(i) >= b) return i;
    return 14;
  endfunction

  function automatic int clamp132(input longint v);
    if (v < 1) return 1;
    if (v > 32) return 32;
    return int'(v);
  endfunction

  // Independent model of the search written from the requirements
  task automatic model(input int tgt, input int rf, output int em, output int en,
                       output int epl, output longint ef, output bit enm);
    longint t, v, vmax, best, vk, nl, nh, vco, fr, dl;
    int li, hi;
    bit stop;
    t = 2 * tgt;
    v = t + t / 50;
    vmax = (v > 2064) ? v : 2064;
    hi = first_idx(clamp132((vmax + v - 1) / v));
    li = first_idx(clamp132(1000 / v));
    best = 64'h7fffffff_ffffffff;
    em = 255; en = 8; epl = 1; ef = 0; enm = 1; stop = 0;
    for (int p = li; p <= hi && !stop; p++) begin
      vk = t * tab_div(p);
      for (int m = 1; m <= 255 && !stop; m++) begin
        if (rf < 12 * m || rf >= 39 * m) continue;
        nl = vk * m / rf;
        nh = (vk * m + rf - 1) / rf;
        if (nl > 255) continue;
        for (longint n = nl; n <= nh && !stop; n++) begin
          if (n < 8) continue;
          if (n > 255) break;
          vco = rf * n / m;
          if (vco >= 1000 && vco <= vmax) begin
            fr = (vco + tab_div(p) / 2) / tab_div(p);
            dl = (fr >= t) ? fr - t : t - fr;
            if (dl < best) begin
              best = dl; em = m; en = int'(n); epl = p; ef = fr; enm = 0;
            end
            if (dl == 0) stop = 1;
          end
        end
      end
    end
  endtask

  task automatic pulse_start(input int tgt, input int rf);
    @(negedge clk);
    target_mhz = 16'(tgt);
    ref_mhz    = 16'(rf);
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_result(input string req, input int tgt, input int rf);
    int em, en, epl;
    longint ef;
    bit enm;
    model(tgt, rf, em, en, epl, ef, enm);
    chk(req, "m", m_out, em);
    chk(req, "n", n_out, en);
    chk(req, "pl", pl_out, epl);
    chk(req, "freq", freq_out, ef);
    chk(req, "no_match", no_match, enm);
  endtask

  task automatic t_reset();
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "no_match after reset", no_match, 0);
  endtask

  // 72 MHz on 12 MHz: index 5 gives VCO 864 (too low), index 6 hits exactly
  task automatic t_hand();
    pulse_start(72, 12);
    chk("R1", "busy after start", busy, 1);
    chk("R1", "done after start", done, 0);
    wait_done();
    chk("R5", "hand m", m_out, 1);
    chk("R5", "hand n", n_out, 96);
    chk("R8", "hand pl", pl_out, 6);
    chk("R5", "hand freq", freq_out, 144);
    chk("R8", "hand no_match", no_match, 0);
  endtask

  task automatic t_sweep();
    int tg[6] = '{396, 852, 540, 50, 1000, 333};
    int rf[6] = '{12, 38, 26, 100, 20, 27};
    for (int i = 0; i < 6; i++) begin
      pulse_start(tg[i], rf[i]);
      wait_done();
      check_result((i % 2 == 0) ? "R6" : "R7", tg[i], rf[i]);
      chk("R4", "sweep window", (no_match == 1'b0 &&
          (ref_mhz < 12 * m_out || ref_mhz >= 39 * m_out)), 0);
    end
  endtask

  task automatic t_nomatch();
    pulse_start(300, 11);
    wait_done();
    chk("R9", "m default", m_out, 255);
    chk("R9", "n default", n_out, 8);
    chk("R9", "pl default", pl_out, 1);
    chk("R9", "freq default", freq_out, 0);
    chk("R9", "no_match", no_match, 1);
  endtask

  task automatic t_busy_start();
    pulse_start(396, 12);
    repeat (40) @(negedge clk);
    chk("R2", "still busy", busy, 1);
    target_mhz = 16'd852;
    ref_mhz    = 16'd38;
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
    wait_done();
    check_result("R2", 396, 12);
  endtask

  task automatic t_hold();
    logic [7:0] m0, n0;
    logic [3:0] p0;
    logic [31:0] f0;
    m0 = m_out; n0 = n_out; p0 = pl_out; f0 = freq_out;
    repeat (25) @(negedge clk);
    chk("R3", "done held", done, 1);
    chk("R3", "m held", m_out, m0);
    chk("R3", "n held", n_out, n0);
    chk("R3", "pl held", pl_out, p0);
    chk("R3", "freq held", freq_out, f0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    target_mhz = '0;
    ref_mhz = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_hand();
    t_hold();
    t_sweep();
    t_nomatch();
    t_busy_start();
    report();
  end

endmodule